// File: doc/BRIEF.md
# Addressable RGB LED String Register Front-End

This block is the bus-facing half of a controller for a daisy-chained string of serially addressed RGB LEDs. Software programs frame length, colour ordering, bit-cell timing and latch timing through a small 32-bit register window. It then streams one 32-bit colour word per LED into a 32-entry pixel FIFO, either by writing a data register or through a DMA request/acknowledge handshake. A downstream bit serializer drains the FIFO over a valid/ready pixel port and receives the timing and ordering settings on dedicated configuration outputs.

The block counts pixels handed to the serializer against the programmed frame length. It raises a sticky "transfer finished" flag when the frame completes. It also raises a sticky "CPU refill" flag, or asserts the DMA request, whenever the FIFO fill level drops to the programmed trigger level. Both flags are cleared by writing 1. They are combined with per-flag enables and a global enable into one interrupt line.

Register offsets (byte addresses): CTRL 0x00, BITTIME 0x04, LATCH 0x08, PIXEL 0x0C, REFILL 0x10, IRQEN 0x14, STATUS 0x18. Any register not listed for reading returns 0.

Top module: `led_string_front`

## Requirements
- R1: After reset every register reads 0, and irq, dma_req and pix_valid are low.
- R2: CTRL holds length in bits 28:16 and colour order in bits 8:6; ser_order mirrors the order field; bit 0 reads 1 exactly while a frame is active. When no frame is active, a CTRL write stores length and order; if its bit 0 is 0 it also empties the pixel FIFO.
- R3: A CTRL write with bit 0 set starts a frame only if no frame is active, the FIFO is empty and the written length is nonzero. Otherwise no frame starts. Every CTRL write during an active frame is ignored, and the stored length and order do not change.
- R4: The FIFO holds 32 words and returns them in write order. PIXEL writes push only during an active frame. Pushes while idle, and pushes into a full FIFO, are dropped.
- R5: pix_valid is high while a frame is active and the FIFO is not empty. Each valid/ready handshake pops one word. The frame ends after the programmed number of handshakes, and any surplus words stay in the FIFO.
- R6: STATUS bit 0 (finished) sets when the last pixel of a frame is handed over. It is cleared by writing 1 to that bit.
- R7: STATUS bit 1 (CPU refill) sets on each cycle in which a frame is active, DMA is disabled and the fill level is at most the trigger level. It is cleared by writing 1, but a set in the same cycle as the clear wins.
- R8: dma_req is high while DMA is enabled, a frame is active and the fill level is at most the trigger level. A dma_ack while dma_req is high pushes dma_data; dma_ack while dma_req is low is ignored. In DMA mode the CPU refill flag never sets.
- R9: STATUS bits 15:10 report the current FIFO fill level (0 to 32).
- R10: irq = IRQEN bit 5 AND ((IRQEN bit 1 AND refill flag) OR (IRQEN bit 0 AND finished flag)).
- R11: BITTIME keeps bits 26:0 except 15:11 (four bit-cell fields at 26:21, 20:16, 10:6, 5:0) and drives ser_bit_timing. LATCH keeps a 13-bit latch duration at 28:16 and a 10-bit LED count at 9:0, driving ser_latch_cycles and ser_led_count. All other bits read 0.
- R12: REFILL holds the DMA enable in bit 5 and the 5-bit trigger level in bits 4:0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register byte address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| dma_req | output | 1 | DMA refill request |
| dma_ack | input | 1 | DMA word strobe |
| dma_data | input | DATA_W | DMA pixel word |
| pix_valid | output | 1 | Pixel available to serializer |
| pix_ready | input | 1 | Serializer accepts pixel |
| pix_data | output | DATA_W | Pixel word at FIFO head |
| ser_order | output | 3 | Colour order code |
| ser_bit_timing | output | 32 | Bit-cell timing fields |
| ser_latch_cycles | output | 13 | Latch (reset) duration |
| ser_led_count | output | 10 | Highest LED index |
| irq | output | 1 | Interrupt request |

## Verification
The checker watches on every cycle that the fill level stays within depth, and that a pixel is offered only inside a frame with data present. It also checks that a lone pop lowers the level by one, that irq never rises without the global enable, that dma_req stays low with DMA disabled, and that a CTRL write cannot end an active frame. Only the directed scenarios can show data ordering through the FIFO, dropping on overflow and while idle, and the refusal to start with stale FIFO contents. The same holds for the set-over-clear race of the refill flag and the exact cycle where the finished flag appears.

// File: rtl/led_front_pkg.sv
package led_front_pkg;
    localparam logic [7:0] OFF_CTRL    = 8'h00;
    localparam logic [7:0] OFF_BITTIME = 8'h04;
    localparam logic [7:0] OFF_LATCH   = 8'h08;
    localparam logic [7:0] OFF_PIXEL   = 8'h0C;
    localparam logic [7:0] OFF_REFILL  = 8'h10;
    localparam logic [7:0] OFF_IRQEN   = 8'h14;
    localparam logic [7:0] OFF_STATUS  = 8'h18;

    localparam int LEN_W   = 13;
    localparam int ORD_W   = 3;
    localparam int LATCH_W = 13;
    localparam int LEDN_W  = 10;
    localparam int TRIG_W  = 5;
    localparam int LVL_W   = 6;

    localparam logic [31:0] BITTIME_MASK = 32'h07FF_07FF;

    typedef struct packed {
        logic [LEN_W-1:0]   len;
        logic [ORD_W-1:0]   order;
        logic [31:0]        bit_time;
        logic [LATCH_W-1:0] latch_cyc;
        logic [LEDN_W-1:0]  led_cnt;
        logic               dma_en;
        logic [TRIG_W-1:0]  trig;
        logic               gie;
        logic               en_cpu;
        logic               en_done;
    } cfg_t;
endpackage

// File: rtl/led_pix_fifo.sv
module led_pix_fifo #(
    parameter int DEPTH  = 32,
    parameter int DATA_W = 32,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush,
    input  logic              push,
    input  logic [DATA_W-1:0] push_data,
    input  logic              pop,
    output logic [DATA_W-1:0] head,
    output logic [CNT_W-1:0]  count,
    output logic              empty,
    output logic              full
);
    typedef struct packed {
        logic [PTR_W-1:0] wp;
        logic [PTR_W-1:0] rp;
        logic [CNT_W-1:0] cnt;
    } fifo_st_t;

    fifo_st_t st_d, st_q;
    logic [DATA_W-1:0] mem [DEPTH];
    logic push_ok, pop_ok;

    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign empty   = (st_q.cnt == '0);
    assign full    = (st_q.cnt == CNT_W'(DEPTH));
    assign push_ok = push && !full;
    assign pop_ok  = pop && !empty;
    assign head    = mem[st_q.rp];
    assign count   = st_q.cnt;

    always_comb begin
        st_d = st_q;
        if (flush) begin
            st_d = '0;
        end else begin
            if (push_ok) st_d.wp = bump(st_q.wp);
            if (pop_ok)  st_d.rp = bump(st_q.rp);
            case ({push_ok, pop_ok})
                2'b10:   st_d.cnt = st_q.cnt + 1'b1;
                2'b01:   st_d.cnt = st_q.cnt - 1'b1;
                default: st_d.cnt = st_q.cnt;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk) begin
        if (push_ok && !flush) mem[st_q.wp] <= push_data;
    end
endmodule

// File: rtl/led_frame_ctl.sv
module led_frame_ctl #(
    parameter int LEN_W = 13
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_req,
    input  logic [LEN_W-1:0] start_len,
    input  logic             fifo_empty,
    input  logic             pix_ready,
    output logic             active,
    output logic             pix_valid,
    output logic             frame_end
);
    typedef struct packed {
        logic             active;
        logic [LEN_W-1:0] remain;
    } frm_st_t;

    frm_st_t st_d, st_q;
    logic pop;

    assign active    = st_q.active;
    assign pix_valid = st_q.active && !fifo_empty;
    assign pop       = pix_valid && pix_ready;
    assign frame_end = pop && (st_q.remain == LEN_W'(1));

    always_comb begin
        st_d = st_q;
        if (!st_q.active) begin
            if (start_req && fifo_empty && (start_len != '0)) begin
                st_d.active = 1'b1;
                st_d.remain = start_len;
            end
        end else if (pop) begin
            st_d.remain = st_q.remain - 1'b1;
            if (st_q.remain == LEN_W'(1)) st_d.active = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/led_irq_unit.sv
module led_irq_unit (
    input  logic clk,
    input  logic rst_n,
    input  logic set_done,
    input  logic set_cpu,
    input  logic clr_wr,
    input  logic clr_done,
    input  logic clr_cpu,
    input  logic gie,
    input  logic en_done,
    input  logic en_cpu,
    output logic flag_done,
    output logic flag_cpu,
    output logic irq
);
    typedef struct packed {
        logic done;
        logic cpu;
    } flag_st_t;

    flag_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clr_wr && clr_done) st_d.done = 1'b0;
        if (clr_wr && clr_cpu)  st_d.cpu  = 1'b0;
        if (set_done) st_d.done = 1'b1;
        if (set_cpu)  st_d.cpu  = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign flag_done = st_q.done;
    assign flag_cpu  = st_q.cpu;
    assign irq       = gie && ((en_done && st_q.done) || (en_cpu && st_q.cpu));
endmodule

// File: rtl/led_string_front.sv
module led_string_front
    import led_front_pkg::*;
#(
    parameter int DEPTH  = 32,
    parameter int DATA_W = 32,
    parameter int ADDR_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               reg_wr,
    input  logic [ADDR_W-1:0]  reg_addr,
    input  logic [31:0]        reg_wdata,
    output logic [31:0]        reg_rdata,
    output logic               dma_req,
    input  logic               dma_ack,
    input  logic [DATA_W-1:0]  dma_data,
    output logic               pix_valid,
    input  logic               pix_ready,
    output logic [DATA_W-1:0]  pix_data,
    output logic [ORD_W-1:0]   ser_order,
    output logic [31:0]        ser_bit_timing,
    output logic [LATCH_W-1:0] ser_latch_cycles,
    output logic [LEDN_W-1:0]  ser_led_count,
    output logic               irq
);
    localparam int CNT_W = $clog2(DEPTH + 1);

    cfg_t cfg_d, cfg_q;
    logic wr_ctrl, wr_bit, wr_latch, wr_pix, wr_refill, wr_irqen, wr_status;
    logic frame_active, frame_end, start_req, flush;
    logic [CNT_W-1:0] fifo_cnt;
    logic fifo_empty, fifo_full;
    logic px_push, dma_push, push;
    logic [DATA_W-1:0] push_data;
    logic below_trig, cpu_set;
    logic flag_done, flag_cpu;

    function automatic logic hit(input logic [ADDR_W-1:0] a, input logic [7:0] off);
        return a == ADDR_W'(off);
    endfunction

    assign wr_ctrl   = reg_wr && hit(reg_addr, OFF_CTRL);
    assign wr_bit    = reg_wr && hit(reg_addr, OFF_BITTIME);
    assign wr_latch  = reg_wr && hit(reg_addr, OFF_LATCH);
    assign wr_pix    = reg_wr && hit(reg_addr, OFF_PIXEL);
    assign wr_refill = reg_wr && hit(reg_addr, OFF_REFILL);
    assign wr_irqen  = reg_wr && hit(reg_addr, OFF_IRQEN);
    assign wr_status = reg_wr && hit(reg_addr, OFF_STATUS);

    assign start_req = wr_ctrl && reg_wdata[0] && !frame_active;
    assign flush     = wr_ctrl && !reg_wdata[0] && !frame_active;

    always_comb begin
        cfg_d = cfg_q;
        if (wr_ctrl && !frame_active) begin
            cfg_d.len   = reg_wdata[28:16];
            cfg_d.order = reg_wdata[8:6];
        end
        if (wr_bit) cfg_d.bit_time = reg_wdata & BITTIME_MASK;
        if (wr_latch) begin
            cfg_d.latch_cyc = reg_wdata[28:16];
            cfg_d.led_cnt   = reg_wdata[9:0];
        end
        if (wr_refill) begin
            cfg_d.dma_en = reg_wdata[5];
            cfg_d.trig   = reg_wdata[4:0];
        end
        if (wr_irqen) begin
            cfg_d.gie     = reg_wdata[5];
            cfg_d.en_cpu  = reg_wdata[1];
            cfg_d.en_done = reg_wdata[0];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    assign below_trig = (fifo_cnt <= CNT_W'(cfg_q.trig));
    assign dma_req    = cfg_q.dma_en && frame_active && below_trig;
    assign cpu_set    = !cfg_q.dma_en && frame_active && below_trig;
    assign px_push    = wr_pix && frame_active;
    assign dma_push   = dma_ack && dma_req && !px_push;
    assign push       = px_push || dma_push;
    assign push_data  = px_push ? DATA_W'(reg_wdata) : dma_data;

    led_pix_fifo #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .flush     (flush),
        .push      (push),
        .push_data (push_data),
        .pop       (pix_valid && pix_ready),
        .head      (pix_data),
        .count     (fifo_cnt),
        .empty     (fifo_empty),
        .full      (fifo_full)
    );

    led_frame_ctl #(.LEN_W(LEN_W)) u_frame (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_req  (start_req),
        .start_len  (reg_wdata[28:16]),
        .fifo_empty (fifo_empty),
        .pix_ready  (pix_ready),
        .active     (frame_active),
        .pix_valid  (pix_valid),
        .frame_end  (frame_end)
    );

    led_irq_unit u_irq (
        .clk       (clk),
        .rst_n     (rst_n),
        .set_done  (frame_end),
        .set_cpu   (cpu_set),
        .clr_wr    (wr_status),
        .clr_done  (reg_wdata[0]),
        .clr_cpu   (reg_wdata[1]),
        .gie       (cfg_q.gie),
        .en_done   (cfg_q.en_done),
        .en_cpu    (cfg_q.en_cpu),
        .flag_done (flag_done),
        .flag_cpu  (flag_cpu),
        .irq       (irq)
    );

    always_comb begin
        reg_rdata = '0;
        if (hit(reg_addr, OFF_CTRL))
            reg_rdata = {3'b0, cfg_q.len, 7'b0, cfg_q.order, 5'b0, frame_active};
        else if (hit(reg_addr, OFF_BITTIME))
            reg_rdata = cfg_q.bit_time;
        else if (hit(reg_addr, OFF_LATCH))
            reg_rdata = {3'b0, cfg_q.latch_cyc, 6'b0, cfg_q.led_cnt};
        else if (hit(reg_addr, OFF_REFILL))
            reg_rdata = {26'b0, cfg_q.dma_en, cfg_q.trig};
        else if (hit(reg_addr, OFF_IRQEN))
            reg_rdata = {26'b0, cfg_q.gie, 3'b0, cfg_q.en_cpu, cfg_q.en_done};
        else if (hit(reg_addr, OFF_STATUS))
            reg_rdata = {16'b0, LVL_W'(fifo_cnt), 8'b0, flag_cpu, flag_done};
    end

    assign ser_order        = cfg_q.order;
    assign ser_bit_timing   = cfg_q.bit_time;
    assign ser_latch_cycles = cfg_q.latch_cyc;
    assign ser_led_count    = cfg_q.led_cnt;
endmodule

// File: rtl/led_front_chk.sv
module led_front_chk
    import led_front_pkg::*;
#(
    parameter int DEPTH  = 32,
    parameter int ADDR_W = 8,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              reg_wr,
    input logic [ADDR_W-1:0] reg_addr,
    input logic              dma_ack,
    input logic              dma_req,
    input logic              pix_valid,
    input logic              pix_ready,
    input logic              irq,
    input logic              gie,
    input logic              dma_en,
    input logic              active,
    input logic [CNT_W-1:0]  fifo_cnt
);
    logic pix_wr, ctrl_wr;
    assign pix_wr  = reg_wr && (reg_addr == ADDR_W'(OFF_PIXEL));
    assign ctrl_wr = reg_wr && (reg_addr == ADDR_W'(OFF_CTRL));

    a_r4_level_bound: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_cnt <= CNT_W'(DEPTH));

    a_r5_valid_in_frame: assert property (@(posedge clk) disable iff (!rst_n)
        pix_valid |-> (active && fifo_cnt != '0));

    a_r5_pop_lowers: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_valid && pix_ready && !pix_wr && !dma_ack) |=> (fifo_cnt == $past(fifo_cnt) - 1'b1));

    a_r10_irq_gated: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> gie);

    a_r8_no_req_cpu_mode: assert property (@(posedge clk) disable iff (!rst_n)
        !dma_en |-> !dma_req);

    a_r3_ctrl_keeps_frame: assert property (@(posedge clk) disable iff (!rst_n)
        (active && ctrl_wr && !(pix_valid && pix_ready)) |=> active);
endmodule

bind led_string_front led_front_chk #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_wr    (reg_wr),
    .reg_addr  (reg_addr),
    .dma_ack   (dma_ack),
    .dma_req   (dma_req),
    .pix_valid (pix_valid),
    .pix_ready (pix_ready),
    .irq       (irq),
    .gie       (cfg_q.gie),
    .dma_en    (cfg_q.dma_en),
    .active    (frame_active),
    .fifo_cnt  (fifo_cnt)
);

// File: tb/tb_led_string_front.sv
`timescale 1ns/1ps
module tb_led_string_front;
    localparam real HALF = 2.5;
    localparam logic [7:0] A_CTRL = 8'h00, A_BIT = 8'h04, A_LATCH = 8'h08, A_PIX = 8'h0C,
                           A_REFILL = 8'h10, A_IRQEN = 8'h14, A_STAT = 8'h18;

    logic clk = 1'b0, rst_n = 1'b0;
    logic reg_wr = 1'b0;
    logic [7:0] reg_addr = '0;
    logic [31:0] reg_wdata = '0, reg_rdata;
    logic dma_req, dma_ack = 1'b0;
    logic [31:0] dma_data = '0;
    logic pix_valid, pix_ready = 1'b0;
    logic [31:0] pix_data;
    logic [2:0] ser_order;
    logic [31:0] ser_bit_timing;
    logic [12:0] ser_latch_cycles;
    logic [9:0] ser_led_count;
    logic irq;
    int compared = 0, mismatched = 0;

    always #(HALF) clk = ~clk;

    led_string_front dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .dma_req(dma_req),
        .dma_ack(dma_ack), .dma_data(dma_data), .pix_valid(pix_valid),
        .pix_ready(pix_ready), .pix_data(pix_data), .ser_order(ser_order),
        .ser_bit_timing(ser_bit_timing), .ser_latch_cycles(ser_latch_cycles),
        .ser_led_count(ser_led_count), .irq(irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0; reg_wdata = '0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        reg_addr = a;
        #0.5;
        d = reg_rdata;
    endtask

    task automatic level(output logic [31:0] l);
        logic [31:0] s;
        rd(A_STAT, s);
        l = (s >> 10) & 32'h3F;
    endtask

    task automatic drain(input int n, input logic [31:0] base, input string req);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            chk({req, " valid"}, {31'b0, pix_valid}, 32'd1);
            chk({req, " data"}, pix_data, base + 32'(i));
            pix_ready = 1'b1;
        end
        @(negedge clk);
        pix_ready = 1'b0;
    endtask

    task automatic push_n(input int n, input logic [31:0] base);
        for (int i = 0; i < n; i++) wr(A_PIX, base + 32'(i));
    endtask

    task automatic t_reset;
        logic [31:0] v;
        rd(A_CTRL, v);   chk("R1 ctrl", v, 0);
        rd(A_STAT, v);   chk("R1 status", v, 0);
        rd(A_REFILL, v); chk("R1 refill", v, 0);
        chk("R1 outs", {29'b0, irq, dma_req, pix_valid}, 0);
    endtask

    task automatic t_cfg;
        logic [31:0] v;
        wr(A_BIT, 32'hFFFF_FFFF);
        rd(A_BIT, v); chk("R11 bittime", v, 32'h07FF_07FF);
        chk("R11 ser_bit_timing", ser_bit_timing, 32'h07FF_07FF);
        wr(A_LATCH, 32'hFFFF_FFFF);
        rd(A_LATCH, v); chk("R11 latch", v, 32'h1FFF_03FF);
        chk("R11 ser outs", {ser_latch_cycles, 9'b0, ser_led_count}, {13'h1FFF, 9'b0, 10'h3FF});
        wr(A_REFILL, 32'hFFFF_FFFF);
        rd(A_REFILL, v); chk("R12 refill", v, 32'h3F);
        wr(A_REFILL, 0);
    endtask

    task automatic t_ctrl_idle;
        logic [31:0] v;
        wr(A_CTRL, 32'h0007_0140);
        rd(A_CTRL, v); chk("R2 ctrl store", v, 32'h0007_0140);
        chk("R2 ser_order", {29'b0, ser_order}, 5);
        wr(A_CTRL, 32'h0000_0001);
        rd(A_CTRL, v); chk("R3 zero length no start", v, 0);
        wr(A_PIX, 32'hDEAD);
        level(v); chk("R4 idle push dropped", v, 0);
    endtask

    task automatic t_frame_basic;
        logic [31:0] v;
        wr(A_CTRL, 32'h0003_0001);
        rd(A_CTRL, v); chk("R2 enable reads active", v, 32'h0003_0001);
        push_n(3, 32'hA0);
        level(v); chk("R9 level 3", v, 3);
        drain(3, 32'hA0, "R5 basic");
        rd(A_STAT, v); chk("R6 done set", v & 1, 1);
        rd(A_CTRL, v); chk("R5 frame over", v & 1, 0);
        wr(A_STAT, 3);
        rd(A_STAT, v); chk("R6 w1c clear", v, 0);
    endtask

    task automatic t_overflow;
        logic [31:0] v;
        wr(A_CTRL, 32'h0028_0001);
        push_n(34, 32'h0);
        level(v); chk("R4 full level", v, 32);
        drain(32, 32'h0, "R4 order/drop");
        push_n(8, 32'h100);
        drain(8, 32'h100, "R4 tail");
        rd(A_STAT, v); chk("R6 done after 40", v & 1, 1);
        wr(A_STAT, 3);
    endtask

    task automatic t_leftover;
        logic [31:0] v;
        wr(A_CTRL, 32'h0002_0001);
        push_n(3, 32'h200);
        drain(2, 32'h200, "R5 short frame");
        level(v); chk("R5 surplus stays", v, 1);
        chk("R5 no valid idle", {31'b0, pix_valid}, 0);
        wr(A_CTRL, 32'h0005_0001);
        rd(A_CTRL, v); chk("R3 start blocked nonempty", v, 32'h0005_0000);
        wr(A_CTRL, 32'h0005_0000);
        level(v); chk("R2 flush", v, 0);
        wr(A_CTRL, 32'h0005_0001);
        rd(A_CTRL, v); chk("R3 start after flush", v, 32'h0005_0001);
        wr(A_CTRL, 32'h0009_01C1);
        rd(A_CTRL, v); chk("R3 ctrl ignored active", v, 32'h0005_0001);
        push_n(5, 32'h300);
        drain(5, 32'h300, "R3 frame len kept");
        rd(A_CTRL, v); chk("R3 ended at 5", v & 1, 0);
        wr(A_STAT, 3);
    endtask

    task automatic t_cpu_flag;
        logic [31:0] v;
        wr(A_REFILL, 32'h04);
        wr(A_CTRL, 32'h000A_0001);
        @(negedge clk);
        rd(A_STAT, v); chk("R7 flag set low level", v & 2, 2);
        wr(A_STAT, 2);
        rd(A_STAT, v); chk("R7 set wins over clear", v & 2, 2);
        push_n(5, 32'h400);
        wr(A_STAT, 2);
        @(negedge clk);
        rd(A_STAT, v); chk("R7 cleared above trig", v & 2, 0);
        drain(1, 32'h400, "R7 pop");
        @(negedge clk);
        rd(A_STAT, v); chk("R7 set at trig", v & 2, 2);
        push_n(5, 32'h405);
        drain(9, 32'h401, "R7 rest");
        wr(A_STAT, 3);
        rd(A_STAT, v); chk("R7 idle no set", v, 0);
    endtask

    task automatic t_dma;
        logic [31:0] v;
        wr(A_REFILL, 32'h30);
        wr(A_CTRL, 32'h0014_0001);
        @(negedge clk);
        chk("R8 req", {31'b0, dma_req}, 1);
        rd(A_STAT, v); chk("R8 no cpu flag", v & 2, 0);
        for (int i = 0; i < 17; i++) begin
            dma_ack = 1'b1; dma_data = 32'h500 + 32'(i);
            @(negedge clk);
        end
        dma_ack = 1'b0;
        level(v); chk("R8 dma level", v, 17);
        chk("R8 req drops", {31'b0, dma_req}, 0);
        dma_ack = 1'b1; dma_data = 32'hBAD;
        @(negedge clk);
        dma_ack = 1'b0;
        level(v); chk("R8 ack ignored", v, 17);
        drain(17, 32'h500, "R8 dma data");
        push_n(3, 32'h511);
        drain(3, 32'h511, "R8 tail");
        wr(A_STAT, 3);
        wr(A_REFILL, 0);
    endtask

    task automatic t_irq;
        wr(A_CTRL, 32'h0001_0001);
        wr(A_PIX, 32'h77);
        drain(1, 32'h77, "R10 frame");
        wr(A_STAT, 2);
        wr(A_IRQEN, 32'h01);
        chk("R10 gie off", {31'b0, irq}, 0);
        wr(A_IRQEN, 32'h21);
        chk("R10 done irq", {31'b0, irq}, 1);
        wr(A_IRQEN, 32'h22);
        chk("R10 other enable", {31'b0, irq}, 0);
        wr(A_IRQEN, 32'h21);
        wr(A_STAT, 1);
        chk("R10 cleared", {31'b0, irq}, 0);
    endtask

    initial begin
        #(HALF * 2 * 200000);
        mismatched++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_cfg();
        t_ctrl_idle();
        t_frame_basic();
        t_overflow();
        t_leftover();
        t_cpu_flag();
        t_dma();
        t_irq();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule